// File: doc/BRIEF.md
# Split Enable/Clear Interrupt Controller

This block gathers interrupt requests from five sources (external, timer 1, timer 2, asynchronous serial, synchronous serial) into one level request to a host processor. Each source has an enable bit and a pending latch. A request raised while its enable is set is held in the pending latch until software clears it. The combined output stays high while any latch holds a request.

A single 16-bit register serves both directions, with a different meaning for each. A write loads the five enable bits from the low byte. In the same write, each 1 in bits 8 to 12 clears the matching pending latch. A read returns the enables in the low byte and, in bits 8 to 12, the pending latches rather than what was written there.

Each source has a two-state machine. `SRC_IDLE` moves to `SRC_PEND` on an enabled request (transition "capture"). `SRC_PEND` returns to `SRC_IDLE` on a clear that arrives without a fresh enabled request (transition "release"). In every other case the state holds (transitions "wait" and "hold").

Top module: `split_irq_ctrl`

## Requirements
- R1: While reset (`rst_n` low) is asserted and right after it, every enable bit and every pending latch is zero: `rd_data_o` reads 0x0000 and `irq_o` is 0.
- R2: A write (`wr_en_i` high at a rising edge) loads `wr_data_i[4:0]` into the enables, and they read back on `rd_data_o[4:0]` from the next cycle on. The bit order is: bit 0 external, bit 1 timer 1, bit 2 timer 2, bit 3 asynchronous serial, bit 4 synchronous serial.
- R3: At a rising edge, `src_req_i[i]` sets pending latch i only if enable i holds 1 in the register at that edge. A request seen while the enable is 0 leaves the latch at 0.
- R4: A pending latch stays set after its request input falls, until it is cleared.
- R5: A write with `wr_data_i[8+i]` = 1 clears pending latch i. A 0 in that bit leaves the latch unchanged.
- R6: If an enabled request and a clear of the same source fall in the same cycle, the request wins and the latch remains set.
- R7: `rd_data_o[12:8]` shows pending latches 0 to 4, in the same source order as the enables. The clear bits written there are never echoed.
- R8: `irq_o` is 1 exactly when at least one pending latch is set.
- R9: Bits 5 to 7 and 13 to 15 of `rd_data_o` always read 0, and writes to those bits have no effect.
- R10: Writing 0 to an enable bit does not clear a request that is already pending for that source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req_i | input | 5 | Request level from each source, in the order of R2 |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data: enables in [4:0], clear bits in [12:8] |
| rd_data_o | output | 16 | Read data: enables in [4:0], pending in [12:8] |
| irq_o | output | 1 | Combined interrupt request to the host |

## Verification
The assertions assume that `src_req_i`, `wr_en_i` and `wr_data_i` are stable and known at each rising edge. They also assume a write lasts exactly the cycle in which its strobe is high. The stimulus meets both assumptions: it changes every input only on the falling clock edge and reads outputs on the next falling edge. Reserved data bits are driven to both 0 and 1, and requests are raised both before and after an enable is changed by a write. This exercises the rule that a write takes effect only at the following edge, without breaking the assumption of stable inputs.

// File: rtl/split_irq_pkg.sv
package split_irq_pkg;

    localparam int unsigned REG_W   = 16;
    localparam int unsigned SRC_N   = 5;
    localparam int unsigned CLR_LSB = 8;

    typedef enum logic [0:0] {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_state_e;

endpackage

// File: rtl/split_irq_src.sv
module split_irq_src
    import split_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic en_i,
    input  logic clr_i,
    output logic pend_o
);

    src_state_e state_q;
    src_state_e state_d;
    logic       capture;

    assign capture = req_i && en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (capture)           state_d = SRC_PEND;
            SRC_PEND: if (clr_i && !capture) state_d = SRC_IDLE;
            default:                          state_d = SRC_IDLE;
        endcase
    end

    always_comb begin
        pend_o = 1'b0;
        unique case (state_q)
            SRC_IDLE: pend_o = 1'b0;
            SRC_PEND: pend_o = 1'b1;
            default:  pend_o = 1'b0;
        endcase
    end

    AST_NO_LATCH_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !(req_i && en_i)) |=> !pend_o); // R3
    AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o); // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && clr_i && !(req_i && en_i)) |=> !pend_o); // R5
    AST_REQUEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && en_i) |=> pend_o); // R6

endmodule

// File: rtl/split_irq_regs.sv
module split_irq_regs
    import split_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned DATA_W  = REG_W,
    parameter int unsigned CLR_POS = CLR_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] clr_o,
    output logic [DATA_W-1:0]  rd_data_o
);

    localparam int unsigned CLR_TOP = CLR_POS + NUM_SRC - 1;

    logic [NUM_SRC-1:0] en_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (wr_en_i) en_q <= wr_data_i[NUM_SRC-1:0];
    end

    assign en_o  = en_q;
    assign clr_o = wr_en_i ? wr_data_i[CLR_TOP:CLR_POS] : '0;

    always_comb begin
        rd_data_o                    = '0;
        rd_data_o[NUM_SRC-1:0]       = en_q;
        rd_data_o[CLR_TOP:CLR_POS]   = pend_i;
    end

    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (rd_data_o[NUM_SRC-1:0] == $past(wr_data_i[NUM_SRC-1:0]))); // R2
    AST_ENABLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(rd_data_o[NUM_SRC-1:0])); // R2

endmodule

// File: rtl/split_irq_ctrl.sv
module split_irq_ctrl
    import split_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_N,
    parameter int unsigned DATA_W  = REG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_o
);

    localparam int unsigned CLR_TOP = CLR_LSB + NUM_SRC - 1;

    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] pend;

    split_irq_regs #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .CLR_POS (CLR_LSB)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .pend_i    (pend),
        .en_o      (en),
        .clr_o     (clr),
        .rd_data_o (rd_data_o)
    );

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        split_irq_src u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (src_req_i[gi]),
            .en_i   (en[gi]),
            .clr_i  (clr[gi]),
            .pend_o (pend[gi])
        );
    end

    assign irq_o = |pend;

    AST_IRQ_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (rd_data_o[CLR_TOP:CLR_LSB] != '0)); // R8
    AST_DISABLE_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && irq_o && (wr_data_i[CLR_TOP:CLR_LSB] == '0)) |=> irq_o); // R10

endmodule

// File: tb/sim_split_irq_ctrl.sv
`timescale 1ns/1ps
module sim_split_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_req_i = '0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    split_irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req_i (src_req_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] wdata;
        logic [4:0]  req;
        logic [15:0] erd;
        logic        eirq;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h001F, 5'b00000, 16'h001F, 1'b0, 8'd2},  // R2 all enables
        '{1'b0, 16'h0000, 5'b00101, 16'h051F, 1'b1, 8'd3},  // R3 ext + timer2
        '{1'b0, 16'h0000, 5'b00000, 16'h051F, 1'b1, 8'd4},  // R4 held
        '{1'b1, 16'h011F, 5'b00000, 16'h041F, 1'b1, 8'd5},  // R5 clear ext only
        '{1'b1, 16'h041F, 5'b00100, 16'h041F, 1'b1, 8'd6},  // R6 request beats clear
        '{1'b1, 16'h041F, 5'b00000, 16'h001F, 1'b0, 8'd8},  // R8 last clear drops irq
        '{1'b1, 16'h0003, 5'b11100, 16'h1C03, 1'b1, 8'd3},  // R3 old enables used at edge
        '{1'b0, 16'h0000, 5'b11111, 16'h1F03, 1'b1, 8'd7},  // R7 all pending shown
        '{1'b1, 16'h1F00, 5'b00000, 16'h0000, 1'b0, 8'd5},  // R5 clear all, disable all
        '{1'b1, 16'hE0E0, 5'b00000, 16'h0000, 1'b0, 8'd9},  // R9 reserved writes ignored
        '{1'b0, 16'h0000, 5'b11111, 16'h0000, 1'b0, 8'd3},  // R3 disabled ignored
        '{1'b1, 16'h0010, 5'b00000, 16'h0010, 1'b0, 8'd2},  // R2 sync serial enable
        '{1'b0, 16'h0000, 5'b10000, 16'h1010, 1'b1, 8'd7},  // R7 bit 12 pending
        '{1'b1, 16'h0000, 5'b00000, 16'h1000, 1'b1, 8'd10}, // R10 disable keeps pending
        '{1'b1, 16'hFF00, 5'b00000, 16'h0000, 1'b0, 8'd9}   // R9 upper reserved ignored
    };

    task automatic check(input logic [15:0] erd, input logic eirq, input int rq);
        checks++;
        if (rd_data_o !== erd || irq_o !== eirq) begin
            errors++;
            $display("FAIL R%0d: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     rq, rd_data_o, irq_o, erd, eirq);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(16'h0000, 1'b0, 1); // R1 during reset
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(16'h0000, 1'b0, 1); // R1 after reset

        for (int i = 0; i < NV; i++) begin
            wr_en_i   = VECS[i].wr;
            wr_data_i = VECS[i].wdata;
            src_req_i = VECS[i].req;
            @(posedge clk);
            @(negedge clk);
            wr_en_i = 1'b0; wr_data_i = '0; src_req_i = '0;
            check(VECS[i].erd, VECS[i].eirq, int'(VECS[i].rq));
        end

        // R1: reset mid-run clears enables and pending
        wr_en_i = 1'b1; wr_data_i = 16'h001F; @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0; src_req_i = 5'b01010; @(posedge clk); @(negedge clk);
        src_req_i = '0;
        check(16'h0A1F, 1'b1, 3); // R3 async + timer1 latched
        rst_n = 1'b0; @(posedge clk); @(negedge clk);
        check(16'h0000, 1'b0, 1); // R1
        rst_n = 1'b1; src_req_i = 5'b11111; @(posedge clk); @(negedge clk);
        src_req_i = '0;
        check(16'h0000, 1'b0, 1); // R1 enables stay zero after reset

        // R5: zero in clear bits leaves latch unchanged
        wr_en_i = 1'b1; wr_data_i = 16'h0002; @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0; src_req_i = 5'b00010; @(posedge clk); @(negedge clk);
        src_req_i = '0;
        wr_en_i = 1'b1; wr_data_i = 16'h1D02; @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
        check(16'h0202, 1'b1, 5); // R5 only bit 9 protects timer1

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule